// File: doc/BRIEF.md
# Size-Aware Shift and Rotate Unit

This block is the combinational shift and rotate datapath of a micro-operation execution stage. It takes a 64-bit source operand, a shift count, an operand size of 1, 2, 4 or 8 bytes, the current carry flag and the previous destination value. It returns the new destination value in the same cycle.

Seven operations are supported:

- logical left shift
- logical right shift
- arithmetic right shift
- rotate left and rotate right
- rotate left and rotate right through carry

The shift count comes either from a full register operand or from an 8-bit immediate. It is trimmed according to the operand size. The shaped field is then merged into the old destination value with the same rule the integer ALU uses. Flag updates from the shifted-out bits are handled elsewhere.

Top module: `shift_rotate_unit`

## Requirements
- R1: The count is `immCount` zero-extended when `useImm` is 1, and `regCount` otherwise. It is then trimmed to its low 6 bits when `sizeSel` is 3 (8 bytes), and to its low 5 bits for `sizeSel` 0, 1 and 2 (1, 2 and 4 bytes). The active width W is 8 << `sizeSel` bits.
- R2: Operation code 0 (logical left shift) moves the active field left by the count. Bits that leave position W-1 are lost. Zeros enter at the bottom. A count of W or more gives an all-zero field.
- R3: Operation code 1 (logical right shift) moves the active field right by the count and fills the vacated top positions of the field with zeros.
- R4: Operation code 2 (arithmetic right shift) fills the vacated top positions with copies of source bit W-1. A count of W or more gives a field of W copies of that bit.
- R5: Operation codes 3 (rotate left) and 4 (rotate right) rotate the W-bit field by the count reduced modulo W. Rotate right moves the low bits of the source to the top of the field.
- R6: Operation codes 5 (rotate left through carry) and 6 (rotate right through carry) rotate a ring of W+1 bits: the field, with `carryIn` above bit W-1. The count is reduced modulo W+1. Rotate right by k puts `carryIn` at bit W-k. Rotate left by k puts it at bit k-1.
- R7: For operation codes 3 to 6, a trimmed count of zero leaves `result` equal to `oldDest` in all 64 bits.
- R8: The merge rule depends on size:
  - For 1- and 2-byte sizes, `result` bits above W are taken from `oldDest`.
  - For the 4-byte size, bits 63:32 are zero.
  - For the 8-byte size, all bits come from the shaped field.
  - Shifts (codes 0 to 2) with a zero count still merge the unmodified field this way.
- R9: Operation code 7 is reserved and returns `oldDest` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 3 | Operation code 0..7 (see R2 to R9) |
| sizeSel | input | 2 | Operand size: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes |
| useImm | input | 1 | Selects `immCount` (1) or `regCount` (0) as the count |
| srcVal | input | 64 | Source operand to be shifted or rotated |
| regCount | input | 64 | Count from a register operand |
| immCount | input | 8 | Count from the immediate field |
| carryIn | input | 1 | Current carry flag, used by the through-carry rotates |
| oldDest | input | 64 | Previous destination register value |
| result | output | 64 | New destination value after shaping and merging |

## Verification
The count trimming and the reduction modulo W or W+1 are internal state of the decode. If either is wrong, the field comes out rotated by the wrong amount, or a zero-count rotate fails to hold the destination, for the same inputs. An error in the field mask shows up immediately at the top boundary of the field: upper destination bits are corrupted for narrow sizes, or stray bits appear above bit 31 for the 4-byte size. Every fault is combinational, so it is visible at `result` for the very input vector that triggers it. The bench therefore compares every applied vector against an independent bit-by-bit model, and also runs hand-worked cases at each size boundary.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  localparam int unsigned XLEN     = 64;
  localparam int unsigned CNT_W    = $clog2(XLEN);
  localparam int unsigned WID_W    = CNT_W + 1;
  localparam int unsigned SIZE_MAX = $clog2(XLEN / 8);
  localparam int unsigned SIZE_W   = $clog2(SIZE_MAX + 1);
  localparam int unsigned IMM_W    = 8;
  // worst case: largest short count divided by the smallest carry ring (9)
  localparam int unsigned RED_STEPS = ((2 ** (CNT_W - 1)) - 1) / 9;

  typedef enum logic [2:0] {
    OP_SLL  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_RSVD = 3'd7
  } shOp_e;

  typedef struct packed {
    logic             pickSll;
    logic             pickSrl;
    logic             pickSra;
    logic             pickRol;
    logic             pickRor;
    logic             pickRcl;
    logic             pickRcr;
    logic             holdDest;
    logic             keepUpper;
    logic [WID_W-1:0] width;
    logic [CNT_W-1:0] amt;
  } shCtrl_t;

endpackage

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
(
  input  logic [2:0]        opSel,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              useImm,
  input  logic [XLEN-1:0]   regCount,
  input  logic [IMM_W-1:0]  immCount,
  output shCtrl_t           ctl
);

  logic [CNT_W-1:0] rawLow;
  logic [CNT_W-1:0] maskedCnt;
  logic [WID_W-1:0] width;
  logic [WID_W-1:0] ringLen;
  logic [WID_W-1:0] ringCnt;
  logic [CNT_W-1:0] plainCnt;
  logic             isWide;
  logic             isRotate;
  logic             isCarryRot;
  logic             unusedCountBits;
  shOp_e            op;

  assign op = shOp_e'(opSel);
  assign unusedCountBits = ^{regCount[XLEN-1:CNT_W], immCount[IMM_W-1:CNT_W]};

  // count source and size-dependent trimming
  assign rawLow    = useImm ? immCount[CNT_W-1:0] : regCount[CNT_W-1:0];
  assign isWide    = (sizeSel == SIZE_W'(SIZE_MAX));
  assign maskedCnt = isWide ? rawLow : {1'b0, rawLow[CNT_W-2:0]};

  assign width   = WID_W'(8) << sizeSel;
  assign ringLen = width + WID_W'(1);

  // plain rotates: W is a power of two, so modulo is a mask
  assign plainCnt = maskedCnt & CNT_W'(width - WID_W'(1));

  // carry rotates: modulo W+1 by bounded conditional subtraction
  always_comb begin
    ringCnt = {1'b0, maskedCnt};
    for (int i = 0; i < RED_STEPS; i++) begin
      if (ringCnt >= ringLen) ringCnt = ringCnt - ringLen;
    end
  end

  assign isCarryRot = (op == OP_RCL) || (op == OP_RCR);
  assign isRotate   = isCarryRot || (op == OP_ROL) || (op == OP_ROR);

  always_comb begin
    ctl           = '0;
    ctl.pickSll   = (op == OP_SLL);
    ctl.pickSrl   = (op == OP_SRL);
    ctl.pickSra   = (op == OP_SRA);
    ctl.pickRol   = (op == OP_ROL);
    ctl.pickRor   = (op == OP_ROR);
    ctl.pickRcl   = (op == OP_RCL);
    ctl.pickRcr   = (op == OP_RCR);
    ctl.holdDest  = (op == OP_RSVD) || (isRotate && (maskedCnt == '0));
    ctl.keepUpper = (sizeSel < SIZE_W'(2));
    ctl.width     = width;
    if (isCarryRot)    ctl.amt = ringCnt[CNT_W-1:0];
    else if (isRotate) ctl.amt = plainCnt;
    else               ctl.amt = maskedCnt;
  end

endmodule

// File: rtl/shift_rotate_path.sv
module shift_rotate_path
  import shift_rotate_pkg::*;
(
  input  shCtrl_t         ctl,
  input  logic [XLEN-1:0] srcVal,
  input  logic            carryIn,
  input  logic [XLEN-1:0] oldDest,
  output logic [XLEN-1:0] result
);

  localparam int unsigned RING_W = XLEN + 1;

  logic [XLEN-1:0]   fieldMask;
  logic [XLEN-1:0]   field;
  logic [CNT_W-1:0]  topIdx;
  logic              signBit;
  logic [WID_W-1:0]  backAmt;
  logic [WID_W-1:0]  ringBack;
  logic [XLEN-1:0]   sllVal;
  logic [XLEN-1:0]   srlVal;
  logic [XLEN-1:0]   sraVal;
  logic [XLEN-1:0]   rolVal;
  logic [XLEN-1:0]   rorVal;
  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] ringMask;
  logic [RING_W-1:0] rclRing;
  logic [RING_W-1:0] rcrRing;
  logic [XLEN-1:0]   shaped;

  // active-width mask, one comparator per bit
  for (genvar gi = 0; gi < XLEN; gi++) begin : g_mask
    assign fieldMask[gi] = (WID_W'(gi) < ctl.width);
  end

  assign field   = srcVal & fieldMask;
  assign topIdx  = CNT_W'(ctl.width - WID_W'(1));
  assign signBit = srcVal[topIdx];

  // shifts
  assign sllVal = (field << ctl.amt) & fieldMask;
  assign srlVal = field >> ctl.amt;
  assign sraVal = srlVal | (signBit ? (fieldMask & ~(fieldMask >> ctl.amt)) : '0);

  // plain rotates within W
  assign backAmt = ctl.width - {1'b0, ctl.amt};
  assign rolVal  = ((field << ctl.amt) | (field >> backAmt)) & fieldMask;
  assign rorVal  = ((field >> ctl.amt) | (field << backAmt)) & fieldMask;

  // carry rotates over a W+1 ring with carry on top
  assign ring     = {1'b0, field} | (RING_W'(carryIn) << ctl.width);
  assign ringMask = {1'b0, fieldMask} | (RING_W'(1) << ctl.width);
  assign ringBack = ctl.width + WID_W'(1) - {1'b0, ctl.amt};
  assign rclRing  = ((ring << ctl.amt) | (ring >> ringBack)) & ringMask;
  assign rcrRing  = ((ring >> ctl.amt) | (ring << ringBack)) & ringMask;

  always_comb begin
    shaped = sllVal;
    if (ctl.pickSrl)      shaped = srlVal;
    else if (ctl.pickSra) shaped = sraVal;
    else if (ctl.pickRol) shaped = rolVal;
    else if (ctl.pickRor) shaped = rorVal;
    else if (ctl.pickRcl) shaped = rclRing[XLEN-1:0] & fieldMask;
    else if (ctl.pickRcr) shaped = rcrRing[XLEN-1:0] & fieldMask;
  end

  // destination merge
  always_comb begin
    if (ctl.holdDest)       result = oldDest;
    else if (ctl.keepUpper) result = (oldDest & ~fieldMask) | shaped;
    else                    result = shaped;
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
(
  input  logic [2:0]        opSel,
  input  logic [SIZE_W-1:0] sizeSel,
  input  logic              useImm,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [XLEN-1:0]   regCount,
  input  logic [IMM_W-1:0]  immCount,
  input  logic              carryIn,
  input  logic [XLEN-1:0]   oldDest,
  output logic [XLEN-1:0]   result
);

  shCtrl_t ctl;

  shift_rotate_ctrl u_ctrl (
    .opSel    (opSel),
    .sizeSel  (sizeSel),
    .useImm   (useImm),
    .regCount (regCount),
    .immCount (immCount),
    .ctl      (ctl)
  );

  shift_rotate_path u_path (
    .ctl     (ctl),
    .srcVal  (srcVal),
    .carryIn (carryIn),
    .oldDest (oldDest),
    .result  (result)
  );

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk
  import shift_rotate_pkg::*;
(
  input logic [2:0]        opSel,
  input logic [SIZE_W-1:0] sizeSel,
  input logic              useImm,
  input logic [XLEN-1:0]   srcVal,
  input logic [XLEN-1:0]   regCount,
  input logic [IMM_W-1:0]  immCount,
  input logic              carryIn,
  input logic [XLEN-1:0]   oldDest,
  input logic [XLEN-1:0]   result
);

  int unsigned w;
  int unsigned k;
  logic [XLEN-1:0] rawCnt;
  logic [XLEN-1:0] lowOnes;
  logic unusedChk;

  assign unusedChk = carryIn;

  always_comb begin
    rawCnt  = useImm ? XLEN'(immCount) : regCount;
    w       = 8 << sizeSel;
    k       = (sizeSel == SIZE_W'(SIZE_MAX)) ? int'(rawCnt[CNT_W-1:0]) : int'(rawCnt[CNT_W-2:0]);
    lowOnes = (k == 0) ? '0 : ({XLEN{1'b1}} >> (XLEN - k));

    if (opSel >= 3'd3 && opSel <= 3'd6 && k == 0)
      AST_ROT_ZERO_HOLD: assert (result == oldDest);  // R7
    if (opSel == 3'd7)
      AST_RSVD_HOLD: assert (result == oldDest);  // R9
    if (sizeSel < SIZE_W'(2))
      AST_NARROW_KEEP_UPPER: assert ((result >> w) == (oldDest >> w));  // R8
    if (sizeSel == SIZE_W'(2) && opSel != 3'd7 && !(opSel >= 3'd3 && k == 0))
      AST_WORD_ZERO_UPPER: assert (result[XLEN-1:32] == '0);  // R8
    if (opSel == 3'd0 && k < w)
      AST_SLL_LOW_CLEAR: assert ((result & lowOnes) == '0);  // R2
    if (opSel == 3'd1 && k > 0 && k < w)
      AST_SRL_TOP_CLEAR: assert (result[w-1] == 1'b0);  // R3
    if (opSel == 3'd2 && k > 0)
      AST_SRA_SIGN_FILL: assert (result[w-1] == srcVal[w-1]);  // R4
  end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (
  .opSel    (opSel),
  .sizeSel  (sizeSel),
  .useImm   (useImm),
  .srcVal   (srcVal),
  .regCount (regCount),
  .immCount (immCount),
  .carryIn  (carryIn),
  .oldDest  (oldDest),
  .result   (result)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

  logic        clk = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic        useImm = 1'b0;
  logic [63:0] srcVal = '0;
  logic [63:0] regCount = '0;
  logic [7:0]  immCount = '0;
  logic        carryIn = 1'b0;
  logic [63:0] oldDest = '0;
  logic [63:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shift_rotate_unit u_dut (
    .opSel(opSel), .sizeSel(sizeSel), .useImm(useImm), .srcVal(srcVal),
    .regCount(regCount), .immCount(immCount), .carryIn(carryIn),
    .oldDest(oldDest), .result(result)
  );

  // bit-level reference model written from the requirements
  function automatic logic [63:0] refCalc(input logic [2:0] op, input logic [1:0] sz,
      input logic ui, input logic [63:0] src, input logic [63:0] rc,
      input logic [7:0] im, input logic cf, input logic [63:0] old);
    int w;
    int k;
    logic [63:0] raw;
    logic [63:0] o;
    logic [64:0] r;
    w   = 8 << sz;
    raw = ui ? {56'd0, im} : rc;
    k   = (sz == 2'd3) ? int'(raw[5:0]) : int'(raw[4:0]);
    if (op == 3'd7) return old;
    if (op >= 3'd3 && k == 0) return old;
    r = '0;
    for (int j = 0; j <= w; j++) r[j] = (j < w) ? src[j] : cf;
    o = '0;
    for (int i = 0; i < w; i++) begin
      case (op)
        3'd0: o[i] = (i - k >= 0) ? src[i - k] : 1'b0;
        3'd1: o[i] = (i + k < w) ? src[i + k] : 1'b0;
        3'd2: o[i] = (i + k < w) ? src[i + k] : src[w - 1];
        3'd3: o[i] = src[(((i - k) % w) + w) % w];
        3'd4: o[i] = src[(i + k) % w];
        3'd5: o[i] = r[(((i - k) % (w + 1)) + (w + 1)) % (w + 1)];
        default: o[i] = r[(i + k) % (w + 1)];
      endcase
    end
    if (sz < 2'd2)
      for (int i = w; i < 64; i++) o[i] = old[i];
    return o;
  endfunction

  task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic ui,
      input logic [63:0] src, input logic [63:0] rc, input logic [7:0] im,
      input logic cf, input logic [63:0] old);
    @(negedge clk);
    opSel = op; sizeSel = sz; useImm = ui; srcVal = src;
    regCount = rc; immCount = im; carryIn = cf; oldDest = old;
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    compared++;
    if (result !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, result, exp);
    end
  endtask

  task automatic t_idle();
    apply(3'd0, 2'd0, 1'b0, '0, '0, '0, 1'b0, '0);
    check("R2 idle zero", 64'h0);
  endtask

  task automatic t_count_mask();
    apply(3'd0, 2'd0, 1'b0, 64'h81, 64'h21, 8'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FF00);
    check("R1 byte count trimmed to 5 bits", 64'hFFFF_FFFF_FFFF_FF02);
    apply(3'd0, 2'd3, 1'b0, 64'h1, 64'h60, 8'h0, 1'b0, '0);
    check("R1 quad count keeps 6 bits", 64'h0000_0001_0000_0000);
    apply(3'd0, 2'd2, 1'b1, 64'h1, 64'hFFFF, 8'hE3, 1'b0, '1);
    check("R1 immediate count", 64'h8);
  endtask

  task automatic t_shifts();
    apply(3'd1, 2'd0, 1'b0, 64'h80, 64'd3, 8'h0, 1'b0, '0);
    check("R3 srl byte", 64'h10);
    apply(3'd2, 2'd0, 1'b0, 64'h80, 64'd3, 8'h0, 1'b0, '0);
    check("R4 sra byte", 64'hF0);
    apply(3'd2, 2'd0, 1'b0, 64'h80, 64'd20, 8'h0, 1'b0, '0);
    check("R4 sra count above width", 64'hFF);
    apply(3'd2, 2'd3, 1'b0, 64'h8000_0000_0000_0000, 64'd63, 8'h0, 1'b0, '0);
    check("R4 sra quad full", 64'hFFFF_FFFF_FFFF_FFFF);
    apply(3'd0, 2'd0, 1'b0, 64'hFF, 64'd9, 8'h0, 1'b0, '0);
    check("R2 sll count above width", 64'h0);
  endtask

  task automatic t_rotates();
    apply(3'd4, 2'd0, 1'b0, 64'h01, 64'd1, 8'h0, 1'b0, '0);
    check("R5 ror byte", 64'h80);
    apply(3'd3, 2'd0, 1'b0, 64'h81, 64'd1, 8'h0, 1'b0, '0);
    check("R5 rol byte", 64'h03);
    apply(3'd3, 2'd0, 1'b0, 64'h81, 64'd8, 8'h0, 1'b0, 64'h5500);
    check("R5 rol by width", 64'h5581);
    apply(3'd3, 2'd0, 1'b0, 64'h81, 64'd9, 8'h0, 1'b0, '0);
    check("R5 rol modulo width", 64'h03);
  endtask

  task automatic t_carry_rotates();
    apply(3'd6, 2'd0, 1'b0, 64'h01, 64'd1, 8'h0, 1'b1, '0);
    check("R6 rcr carry set", 64'h80);
    apply(3'd6, 2'd0, 1'b0, 64'h01, 64'd1, 8'h0, 1'b0, '0);
    check("R6 rcr carry clear", 64'h00);
    apply(3'd5, 2'd0, 1'b0, 64'h80, 64'd1, 8'h0, 1'b1, '0);
    check("R6 rcl carry set", 64'h01);
    apply(3'd5, 2'd0, 1'b0, 64'h80, 64'd9, 8'h0, 1'b1, '0);
    check("R6 rcl full ring", 64'h80);
    apply(3'd5, 2'd1, 1'b0, 64'h8000, 64'd2, 8'h0, 1'b0, '0);
    check("R6 rcl word", 64'h0001);
  endtask

  task automatic t_zero_hold();
    apply(3'd4, 2'd0, 1'b0, 64'hAB, 64'h20, 8'h0, 1'b1, 64'h1234);
    check("R7 ror zero count holds", 64'h1234);
    apply(3'd5, 2'd3, 1'b1, 64'hAB, 64'h0, 8'h40, 1'b1, 64'hDEAD_BEEF_0000_1111);
    check("R7 rcl zero count holds", 64'hDEAD_BEEF_0000_1111);
  endtask

  task automatic t_merge();
    apply(3'd0, 2'd2, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 8'h0, 1'b0, '1);
    check("R8 dword zero-extends", 64'h0000_0000_CCCC_DDDD);
    apply(3'd0, 2'd1, 1'b0, 64'h1234_5678, 64'd0, 8'h0, 1'b0, '1);
    check("R8 word keeps upper", 64'hFFFF_FFFF_FFFF_5678);
    apply(3'd1, 2'd3, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 8'h0, 1'b0, '1);
    check("R8 quad replaces", 64'hAAAA_BBBB_CCCC_DDDD);
  endtask

  task automatic t_reserved();
    apply(3'd7, 2'd3, 1'b0, 64'hFFFF, 64'd5, 8'h0, 1'b1, 64'h0BAD_F00D);
    check("R9 reserved op holds", 64'h0BAD_F00D);
  endtask

  task automatic t_sweep();
    logic [63:0] lf;
    int cnts [13] = '{0, 1, 3, 7, 8, 9, 15, 16, 17, 31, 33, 63, 69};
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int op = 0; op < 7; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int c = 0; c < 13; c++) begin
          logic [63:0] src;
          logic [63:0] old;
          logic ui;
          lf  = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
          src = lf;
          old = {lf[31:0], lf[63:32]};
          ui  = c[0];
          apply(3'(op), 2'(sz), ui, src, 64'(cnts[c]), 8'(cnts[c]), lf[7], old);
          check("R1 R2 R3 R4 R5 R6 R8 sweep",
                refCalc(3'(op), 2'(sz), ui, src, 64'(cnts[c]), 8'(cnts[c]), lf[7], old));
        end
      end
    end
  endtask

  initial begin
    t_idle();
    t_count_mask();
    t_shifts();
    t_rotates();
    t_carry_rotates();
    t_zero_hold();
    t_merge();
    t_reserved();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule